// File: doc/BRIEF.md
# Shadow-Banked Integer Register File

This block is a 64-bit integer register file for a 32-entry register space, with an extra bank of eight shadow registers that stand in for a fixed, non-contiguous set of register indices while the core runs in its privileged mode. Privileged handler code can then use a handful of scratch registers without saving or disturbing the values that ordinary code keeps in those same indices.

The file has two read ports and one write port, each addressed by a 5-bit index. Reads are combinational. Writes take effect at the rising clock edge. A mode input, `priv_mode`, selects the mapping. When it is high, indices 8 to 14 are steered to shadow entries 0 to 6, and index 25 is steered to shadow entry 7. Every other index goes to the main bank. When `priv_mode` is low, all indices use the main bank and the shadow bank is left alone.

Index 31 is a hard zero. An asynchronous active-low reset clears both banks.

Top module: `srf_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, every index on both read ports returns zero in either mode until it is written; a reset in mid-run clears both banks again.
- R2: The read ports are combinational: a change of read index changes the read data within the same cycle, with no clock edge.
- R3: A write with `wr_en` high updates its entry at the rising edge. A read of that entry in the same cycle returns the old value, and later reads return the new one.
- R4: With `priv_mode` high, indices 8 to 14 map to shadow entries 0 to 6. Each of the seven is a separate storage location, distinct from the main-bank entry of the same index.
- R5: With `priv_mode` high, index 25 maps to shadow entry 7, which is separate from main-bank entry 25.
- R6: With `priv_mode` high, all indices other than 8 to 14 and 25 access the main bank. This includes the neighbours 7, 15, 24 and 26.
- R7: With `priv_mode` low, every index accesses the main bank and no write changes any shadow entry.
- R8: Index 31 reads as zero on both ports in both modes, and writes to it are discarded.
- R9: With `wr_en` low, no entry of either bank changes, whatever the values on `wr_idx` and `wr_data`.
- R10: The two read ports are independent: each returns the data of its own index through the same mapping, and both may read the same entry at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| priv_mode | input | 1 | High selects the privileged mapping onto the shadow bank |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |

## Verification
The bench checks the edges of the remapped range: indices 7, 15, 24 and 26 must stay in the main bank, while 8, 14 and 25 must move to the shadow bank. A design with an off-by-one range test would leak one of these into the wrong bank. It writes the same index in both modes and reads it back in both. A remap that ignored the mode, or that let an ordinary-mode write reach a shadow entry, would return the other bank's value. It also fills all eight shadow entries with distinct data and reads each one back, which exposes two shadow indices that alias onto one entry. Finally, it reads an entry in the same cycle it is written, to catch write-through behaviour, and writes index 31 in both modes to show it never holds data.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // Which physical store a register index resolves to
    typedef enum logic [1:0] {
        SEL_MAIN   = 2'd0,
        SEL_SHADOW = 2'd1,
        SEL_ZERO   = 2'd2
    } bank_sel_e;

endpackage

// File: rtl/srf_remap.sv
module srf_remap
    import srf_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int SHADOW_N   = 8,
    parameter int SHADOW_LO  = 8,
    parameter int SHADOW_HI  = 14,
    parameter int SHADOW_ALT = 25
) (
    input  logic                        priv_mode,
    input  logic [IDX_W-1:0]            idx,
    output bank_sel_e                   sel,
    output logic [$clog2(SHADOW_N)-1:0] sh_idx
);
    localparam int SH_W     = $clog2(SHADOW_N);
    localparam int ZERO_IDX = (1 << IDX_W) - 1;

    logic in_range;
    logic is_alt;

    assign in_range = (idx >= IDX_W'(SHADOW_LO)) && (idx <= IDX_W'(SHADOW_HI));
    assign is_alt   = (idx == IDX_W'(SHADOW_ALT));

    always_comb begin
        sel    = SEL_MAIN;
        sh_idx = '0;
        if (idx == IDX_W'(ZERO_IDX)) begin
            sel = SEL_ZERO;
        end else if (priv_mode && in_range) begin
            sel    = SEL_SHADOW;
            sh_idx = SH_W'(idx - IDX_W'(SHADOW_LO));
        end else if (priv_mode && is_alt) begin
            sel    = SEL_SHADOW;
            sh_idx = SH_W'(SHADOW_N - 1);
        end
    end

endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 64,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DEPTH-1:0][DATA_W-1:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    AST_CLEAR_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem)); // R9

endmodule

// File: rtl/srf_regfile.sv
module srf_regfile
    import srf_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int IDX_W      = 5,
    parameter int SHADOW_N   = 8,
    parameter int SHADOW_LO  = 8,
    parameter int SHADOW_HI  = 14,
    parameter int SHADOW_ALT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_mode,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int REG_N    = 1 << IDX_W;
    localparam int SH_W     = $clog2(SHADOW_N);
    localparam int N_RD     = 2;
    localparam int N_PORT   = N_RD + 1;
    localparam int WR_P     = N_RD;
    localparam int ZERO_IDX = REG_N - 1;

    logic [IDX_W-1:0]  p_idx [N_PORT];
    bank_sel_e         p_sel [N_PORT];
    logic [SH_W-1:0]   p_sh  [N_PORT];
    logic [DATA_W-1:0] m_rd  [N_RD];
    logic [DATA_W-1:0] s_rd  [N_RD];
    logic [DATA_W-1:0] rd_out[N_RD];
    logic              main_we;
    logic              sh_we;

    assign p_idx[0]    = rd_a_idx;
    assign p_idx[1]    = rd_b_idx;
    assign p_idx[WR_P] = wr_idx;

    // One index mapper per port
    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        srf_remap #(
            .IDX_W     (IDX_W),
            .SHADOW_N  (SHADOW_N),
            .SHADOW_LO (SHADOW_LO),
            .SHADOW_HI (SHADOW_HI),
            .SHADOW_ALT(SHADOW_ALT)
        ) u_map (
            .priv_mode(priv_mode),
            .idx      (p_idx[p]),
            .sel      (p_sel[p]),
            .sh_idx   (p_sh[p])
        );
    end

    assign main_we = wr_en && (p_sel[WR_P] == SEL_MAIN);
    assign sh_we   = wr_en && (p_sel[WR_P] == SEL_SHADOW);

    srf_bank #(.DEPTH(REG_N), .DATA_W(DATA_W), .AW(IDX_W)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (main_we),
        .waddr  (wr_idx),
        .wdata  (wr_data),
        .raddr_a(rd_a_idx),
        .raddr_b(rd_b_idx),
        .rdata_a(m_rd[0]),
        .rdata_b(m_rd[1])
    );

    srf_bank #(.DEPTH(SHADOW_N), .DATA_W(DATA_W), .AW(SH_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sh_we),
        .waddr  (p_sh[WR_P]),
        .wdata  (wr_data),
        .raddr_a(p_sh[0]),
        .raddr_b(p_sh[1]),
        .rdata_a(s_rd[0]),
        .rdata_b(s_rd[1])
    );

    // Per-port output select
    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        always_comb begin
            unique case (p_sel[r])
                SEL_MAIN:   rd_out[r] = m_rd[r];
                SEL_SHADOW: rd_out[r] = s_rd[r];
                SEL_ZERO:   rd_out[r] = '0;
                default:    rd_out[r] = '0;
            endcase
        end
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == IDX_W'(ZERO_IDX)) |-> (rd_a_data == '0)); // R8

    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == IDX_W'(ZERO_IDX)) |-> (rd_b_data == '0)); // R8

    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_we, sh_we})); // R4

    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_mode |-> !sh_we); // R7

    AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == IDX_W'(ZERO_IDX)) |-> !(main_we || sh_we)); // R8

endmodule

// File: tb/srf_regfile_test.sv
module srf_regfile_test;

    localparam int CLK_HALF = 4;   // 125 MHz

    typedef struct packed {
        logic        pal;
        logic        we;
        logic [4:0]  widx;
        logic [63:0] wdat;
        logic [4:0]  ridx;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 5'd3,  64'hA1,  5'd3,  64'h0},   // R3 same-cycle read sees old
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd3,  64'hA1},  // R3 new value visible
        '{1'b0, 1'b1, 5'd9,  64'hB2,  5'd9,  64'h0},   // R7 main write
        '{1'b1, 1'b0, 5'd0,  64'h0,   5'd9,  64'h0},   // R4 shadow separate, still zero
        '{1'b1, 1'b1, 5'd9,  64'hC3,  5'd9,  64'h0},   // R4 shadow write
        '{1'b1, 1'b0, 5'd0,  64'h0,   5'd9,  64'hC3},  // R4 shadow readback
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd9,  64'hB2},  // R7 main intact
        '{1'b1, 1'b1, 5'd25, 64'hD4,  5'd25, 64'h0},   // R5 shadow entry 7 write
        '{1'b0, 1'b1, 5'd25, 64'hE5,  5'd25, 64'h0},   // R7 main 25 write
        '{1'b1, 1'b0, 5'd0,  64'h0,   5'd25, 64'hD4},  // R5 shadow kept
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd25, 64'hE5},  // R5 main kept
        '{1'b1, 1'b1, 5'd3,  64'hF6,  5'd3,  64'hA1},  // R6 priv read of main 3
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd3,  64'hF6},  // R6 priv write hit main
        '{1'b1, 1'b1, 5'd14, 64'h77,  5'd14, 64'h0},   // R4 top of range
        '{1'b1, 1'b0, 5'd0,  64'h0,   5'd14, 64'h77},  // R4
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd14, 64'h0},   // R4 main 14 untouched
        '{1'b1, 1'b1, 5'd15, 64'h88,  5'd15, 64'h0},   // R6 neighbour 15
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd15, 64'h88},  // R6
        '{1'b1, 1'b1, 5'd7,  64'h99,  5'd7,  64'h0},   // R6 neighbour 7
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd7,  64'h99},  // R6
        '{1'b0, 1'b1, 5'd31, 64'hFF,  5'd31, 64'h0},   // R8 write discarded
        '{1'b1, 1'b1, 5'd31, 64'hFE,  5'd31, 64'h0},   // R8 priv mode
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd31, 64'h0},   // R8
        '{1'b0, 1'b0, 5'd3,  64'h123, 5'd3,  64'hF6},  // R9 disabled write
        '{1'b0, 1'b0, 5'd0,  64'h0,   5'd3,  64'hF6}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_mode = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [4:0]  rd_b_idx = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data;
    logic [63:0] rd_b_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #CLK_HALF clk = ~clk;

    srf_regfile uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .priv_mode(priv_mode),
        .rd_a_idx (rd_a_idx),
        .rd_a_data(rd_a_data),
        .rd_b_idx (rd_b_idx),
        .rd_b_data(rd_b_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; sample 2 ns later, before the rising edge
    task automatic drive(input logic pal, input logic we, input logic [4:0] widx,
                         input logic [63:0] wdat, input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        priv_mode = pal;
        wr_en     = we;
        wr_idx    = widx;
        wr_data   = wdat;
        rd_a_idx  = ra;
        rd_b_idx  = rb;
        #2;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 during reset
        drive(1'b0, 1'b0, 5'd0, 64'h0, 5'd3, 5'd9);
        chk("R1", "read A in reset", rd_a_data, 64'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 5'd0, 64'h0, 5'd9, 5'd25);
        chk("R1", "priv read 9 after reset", rd_a_data, 64'h0);
        chk("R1", "priv read 25 after reset", rd_b_data, 64'h0);

        // Vector table; both ports read the same index (R10)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].pal, VECS[i].we, VECS[i].widx, VECS[i].wdat,
                  VECS[i].ridx, VECS[i].ridx);
            chk("R3/R4/R5/R6/R7/R8/R9", $sformatf("vector %0d port A", i), rd_a_data, VECS[i].exp);
            chk("R10", $sformatf("vector %0d port B", i), rd_b_data, VECS[i].exp);
        end

        // R4 R5: all eight shadow entries distinct
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b1, (k < 7) ? 5'(8 + k) : 5'd25, 64'h5000 + 64'(k), 5'd0, 5'd0);
        end
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b0, 5'd0, 64'h0, (k < 7) ? 5'(8 + k) : 5'd25, 5'd0);
            chk((k < 7) ? "R4" : "R5", $sformatf("shadow entry %0d", k), rd_a_data, 64'h5000 + 64'(k));
        end
        drive(1'b0, 1'b0, 5'd0, 64'h0, 5'd9, 5'd10);
        chk("R7", "main 9 after shadow fill", rd_a_data, 64'hB2);
        chk("R7", "main 10 after shadow fill", rd_b_data, 64'h0);

        // R6: neighbours 24 and 26 stay in main
        drive(1'b1, 1'b1, 5'd24, 64'h24, 5'd0, 5'd0);
        drive(1'b1, 1'b1, 5'd26, 64'h26, 5'd0, 5'd0);
        drive(1'b0, 1'b0, 5'd0, 64'h0, 5'd24, 5'd26);
        chk("R6", "main 24", rd_a_data, 64'h24);
        chk("R6", "main 26", rd_b_data, 64'h26);

        // R10: different indices and mappings on the two ports
        drive(1'b1, 1'b0, 5'd0, 64'h0, 5'd25, 5'd3);
        chk("R10", "port A shadow 25", rd_a_data, 64'h5007);
        chk("R10", "port B main 3", rd_b_data, 64'hF6);

        // R2: change the read index mid-cycle, no clock edge
        drive(1'b0, 1'b0, 5'd0, 64'h0, 5'd3, 5'd0);
        chk("R2", "read 3", rd_a_data, 64'hF6);
        rd_a_idx = 5'd9;
        #1;
        chk("R2", "read 9 same cycle", rd_a_data, 64'hB2);
        priv_mode = 1'b1;
        #1;
        chk("R2", "mode flip same cycle", rd_a_data, 64'h5001);

        // R1: reset in mid-run clears both banks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 5'd0, 64'h0, 5'd3, 5'd9);
        chk("R1", "main 3 after reset", rd_a_data, 64'h0);
        chk("R1", "main 9 after reset", rd_b_data, 64'h0);
        drive(1'b1, 1'b0, 5'd0, 64'h0, 5'd9, 5'd25);
        chk("R1", "shadow 9 after reset", rd_a_data, 64'h0);
        chk("R1", "shadow 25 after reset", rd_b_data, 64'h0);

        @(negedge clk);
        finish_run();
    end

endmodule